// File: doc/BRIEF.md
# Fuse Bank Single-Error Corrector

This block guards the start-up configuration held in a set of fuse banks. Each bank is a 26-bit word. The low 20 bits hold the configuration payload, and the six bits above them hold a check field. A start pulse launches a load scan. The scan visits one bank per clock, from bank 0 to the last bank. For each bank it produces a corrected payload, a flag for a repaired error and a flag for an error it could not repair. One sticky interrupt bit records that some bank showed an error, so the host can judge a programming run.

Correction for a bank is switched on by payload bit 19 of that same bank. A bank with that bit clear is passed through untouched. The code is a Hamming single-error-correcting, double-error-detecting code. Five Hamming bits and one overall parity bit cover the 20 payload bits.

A combinational encoder shares the same code. Given a payload, it returns the full 26-bit word that a programmer should burn into a bank.

Top module: `fuse_ecc_top`

## Requirements
- R1: `encWord` equals {P, C[4:0], payload}. Data bit i sits at codeword position q(i), which is the i-th integer of 3..25 that is not a power of two (q(0)=3, q(1)=5, q(2)=6, ...). Check bit C[k] (word bit 20+k) is the XOR of the data bits whose q(i) has bit k set. P (word bit 25) makes the XOR of all 26 word bits zero.
- R2: A bank that is a valid R1 codeword with bit 19 set yields its payload unchanged, with neither flag set.
- R3: A bank with bit 19 set and exactly one flipped bit anywhere in bits 25:0 yields the original payload. Its corrected flag is set and its uncorrectable flag is clear.
- R4: A bank with bit 19 set and exactly two flipped bits yields its raw low 20 bits unchanged. Its uncorrectable flag is set and its corrected flag is clear.
- R5: A bank whose raw bit 19 is 0 yields its raw low 20 bits, sets neither flag and cannot set the interrupt, whatever its check field holds.
- R6: A start pulse while idle clears all per-bank flags on the edge that samples it. `busy` then stays high for exactly NUM_BANKS cycles. Bank k (counting from 0) gets its result on the (k+1)-th edge after the sampling edge, so banks are handled in ascending order.
- R7: `done` rises on the edge that handles the last bank and holds until the next accepted start. A start that arrives while `busy` is high is ignored.
- R8: `eccIrq` sets on the edge that records any corrected or uncorrectable flag. It stays set until a cycle with `intClr` high clears it. When a clear and a new error fall on the same edge, the set wins.
- R9: After reset, `busy`, `done`, `eccIrq`, all flags and all payload outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse that launches a load scan |
| intClr | input | 1 | Clears the interrupt bit (write-one-to-clear) |
| bankRaw | input | NUM_BANKS*26 | Raw bank words, bank k at bits 26k+25:26k |
| encPayload | input | 20 | Payload to be encoded |
| encWord | output | 26 | Encoded 26-bit bank word for encPayload |
| bankData | output | NUM_BANKS*20 | Corrected payloads, bank k at bits 20k+19:20k |
| bankCorr | output | NUM_BANKS | Per-bank flag: a single error was repaired |
| bankUncorr | output | NUM_BANKS | Per-bank flag: an error could not be repaired |
| busy | output | 1 | A scan is in progress |
| done | output | 1 | The last scan has finished |
| eccIrq | output | 1 | Sticky error interrupt |

## Verification
The assertions assume that `bankRaw` stays stable from an accepted start until `done` rises. They also assume that `intClr` arrives only as a level the host drives between scans or during them. The properties do not model fuse contents, so they hold for any bank values. The directed stimulus changes bank words and encoder inputs only while the block is idle. Each error pattern is built from a clean codeword by flipping chosen bits, which keeps single and double errors distinct from wider corruptions whose outcome the code does not define.

// File: rtl/fuse_ecc_pkg.sv
`timescale 1ns/1ps
package fuse_ecc_pkg;
  localparam int DATA_W = 20;
  localparam int HAM_W  = 5;
  localparam int WORD_W = DATA_W + HAM_W + 1;
  localparam int CODE_N = DATA_W + HAM_W;   // highest Hamming position
  localparam int EN_BIT = DATA_W - 1;       // per-bank correction enable

  typedef struct packed {
    logic [DATA_W-1:0] payload;
    logic              corr;
    logic              uncorr;
  } dec_t;

  typedef struct packed {
    logic clearFlags;   // start accepted: wipe per-bank flags
    logic capture;      // record result for the current bank
  } strobe_t;

  // Hamming check bits: data bits fill the non-power-of-two positions 3..CODE_N
  function automatic logic [HAM_W-1:0] hamCheck(input logic [DATA_W-1:0] d);
    logic [HAM_W-1:0] c;
    int di;
    c  = '0;
    di = 0;
    for (int p = 1; p <= CODE_N; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (d[di]) c ^= HAM_W'(p);
        di++;
      end
    end
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] encodeWord(input logic [DATA_W-1:0] d);
    logic [HAM_W-1:0] c;
    c = hamCheck(d);
    return {^{c, d}, c, d};
  endfunction

  function automatic dec_t decodeWord(input logic [WORD_W-1:0] w);
    dec_t r;
    logic [HAM_W-1:0] syn;
    logic ovr;
    int di;
    r.payload = w[DATA_W-1:0];
    r.corr    = 1'b0;
    r.uncorr  = 1'b0;
    if (w[EN_BIT]) begin
      syn = w[DATA_W +: HAM_W] ^ hamCheck(w[DATA_W-1:0]);
      ovr = ^w;
      if (ovr) begin
        if ((syn & (syn - HAM_W'(1))) == '0) begin
          r.corr = 1'b1;                 // parity or check bit hit, data intact
        end else if (int'(syn) > CODE_N) begin
          r.uncorr = 1'b1;               // points outside the code
        end else begin
          r.corr = 1'b1;
          di = 0;
          for (int p = 1; p <= CODE_N; p++) begin
            if ((p & (p - 1)) != 0) begin
              if (HAM_W'(p) == syn) r.payload[di] = ~r.payload[di];
              di++;
            end
          end
        end
      end else if (syn != '0) begin
        r.uncorr = 1'b1;                 // even weight, nonzero syndrome
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/fuse_ecc_enc.sv
`timescale 1ns/1ps
module fuse_ecc_enc
  import fuse_ecc_pkg::*;
(
  input  logic [DATA_W-1:0] payload,
  output logic [WORD_W-1:0] word
);
  always_comb word = encodeWord(payload);
endmodule

// File: rtl/fuse_ecc_ctrl.sv
`timescale 1ns/1ps
module fuse_ecc_ctrl
  import fuse_ecc_pkg::*;
#(
  parameter int NUM_BANKS = 10,
  localparam int IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  output strobe_t          strobe,
  output logic [IDX_W-1:0] bankIdx,
  output logic             busy,
  output logic             done
);
  typedef enum logic {ST_IDLE, ST_SCAN} state_t;
  state_t state;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BANKS - 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bankIdx <= '0;
      done    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state   <= ST_SCAN;
          bankIdx <= '0;
          done    <= 1'b0;
        end
        ST_SCAN: begin
          if (bankIdx == LAST_IDX) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            bankIdx <= bankIdx + IDX_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy              = (state == ST_SCAN);
    strobe.clearFlags = (state == ST_IDLE) && start;
    strobe.capture    = busy;
  end
endmodule

// File: rtl/fuse_ecc_dp.sv
`timescale 1ns/1ps
module fuse_ecc_dp
  import fuse_ecc_pkg::*;
#(
  parameter int NUM_BANKS = 10,
  localparam int IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  strobe_t                     strobe,
  input  logic [IDX_W-1:0]            bankIdx,
  input  logic                        intClr,
  input  logic [NUM_BANKS*WORD_W-1:0] bankRaw,
  output logic [NUM_BANKS*DATA_W-1:0] bankData,
  output logic [NUM_BANKS-1:0]        bankCorr,
  output logic [NUM_BANKS-1:0]        bankUncorr,
  output logic                        eccIrq
);
  logic [WORD_W-1:0] curWord;
  dec_t              curDec;
  logic [DATA_W-1:0] dataQ [NUM_BANKS];
  logic              errHit;

  always_comb begin
    curWord = bankRaw[bankIdx*WORD_W +: WORD_W];
    curDec  = decodeWord(curWord);
    errHit  = strobe.capture && (curDec.corr || curDec.uncorr);
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dataQ[b]      <= '0;
        bankCorr[b]   <= 1'b0;
        bankUncorr[b] <= 1'b0;
      end else if (strobe.clearFlags) begin
        bankCorr[b]   <= 1'b0;
        bankUncorr[b] <= 1'b0;
      end else if (strobe.capture && (bankIdx == IDX_W'(b))) begin
        dataQ[b]      <= curDec.payload;
        bankCorr[b]   <= curDec.corr;
        bankUncorr[b] <= curDec.uncorr;
      end
    end
    assign bankData[b*DATA_W +: DATA_W] = dataQ[b];
  end

  // sticky interrupt, a new error outranks a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       eccIrq <= 1'b0;
    else if (errHit) eccIrq <= 1'b1;
    else if (intClr) eccIrq <= 1'b0;
  end
endmodule

// File: rtl/fuse_ecc_top.sv
`timescale 1ns/1ps
module fuse_ecc_top
  import fuse_ecc_pkg::*;
#(
  parameter int NUM_BANKS = 10,
  localparam int IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        start,
  input  logic                        intClr,
  input  logic [NUM_BANKS*WORD_W-1:0] bankRaw,
  input  logic [DATA_W-1:0]           encPayload,
  output logic [WORD_W-1:0]           encWord,
  output logic [NUM_BANKS*DATA_W-1:0] bankData,
  output logic [NUM_BANKS-1:0]        bankCorr,
  output logic [NUM_BANKS-1:0]        bankUncorr,
  output logic                        busy,
  output logic                        done,
  output logic                        eccIrq
);
  strobe_t          strobe;
  logic [IDX_W-1:0] bankIdx;

  fuse_ecc_ctrl #(.NUM_BANKS(NUM_BANKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .strobe(strobe),
    .bankIdx(bankIdx), .busy(busy), .done(done)
  );

  fuse_ecc_dp #(.NUM_BANKS(NUM_BANKS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .bankIdx(bankIdx),
    .intClr(intClr), .bankRaw(bankRaw), .bankData(bankData),
    .bankCorr(bankCorr), .bankUncorr(bankUncorr), .eccIrq(eccIrq)
  );

  fuse_ecc_enc u_enc (.payload(encPayload), .word(encWord));
endmodule

// File: rtl/fuse_ecc_chk.sv
`timescale 1ns/1ps
module fuse_ecc_chk #(
  parameter int NUM_BANKS = 10
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 intClr,
  input logic [NUM_BANKS-1:0] bankCorr,
  input logic [NUM_BANKS-1:0] bankUncorr,
  input logic                 busy,
  input logic                 done,
  input logic                 eccIrq
);
  localparam int CW = $clog2(NUM_BANKS + 1) + 1;
  logic [CW-1:0] busyCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     busyCnt <= '0;
    else if (busy) busyCnt <= busyCnt + CW'(1);
    else           busyCnt <= '0;
  end

  p_flags_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    (bankCorr & bankUncorr) == '0);

  p_busy_len_r6: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (busyCnt < CW'(NUM_BANKS)));

  p_busy_full_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyCnt == CW'(NUM_BANKS)));

  p_done_after_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(done && busy));

  p_irq_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (eccIrq && !intClr) |=> eccIrq);

  p_irq_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (intClr && !busy) |=> !eccIrq);

  p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eccIrq) |-> ((bankCorr | bankUncorr) != '0));
endmodule

bind fuse_ecc_top fuse_ecc_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk(clk), .rstN(rstN), .intClr(intClr), .bankCorr(bankCorr),
  .bankUncorr(bankUncorr), .busy(busy), .done(done), .eccIrq(eccIrq)
);

// File: tb/tb_fuse_ecc_top.sv
`timescale 1ns/1ps
module tb_fuse_ecc_top;
  localparam int NB = 10;
  localparam int DW = 20;
  localparam int WW = 26;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic intClr = 1'b0;
  logic [NB*WW-1:0] bankRaw;
  logic [DW-1:0] encPayload = '0;
  logic [WW-1:0] encWord;
  logic [NB*DW-1:0] bankData;
  logic [NB-1:0] bankCorr, bankUncorr;
  logic busy, done, eccIrq;

  logic [WW-1:0] raw [NB];
  logic [DW-1:0] expData [NB];
  int posOf [DW];
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  always_comb for (int b = 0; b < NB; b++) bankRaw[b*WW +: WW] = raw[b];

  fuse_ecc_top #(.NUM_BANKS(NB)) dut (
    .clk(clk), .rstN(rstN), .start(start), .intClr(intClr), .bankRaw(bankRaw),
    .encPayload(encPayload), .encWord(encWord), .bankData(bankData),
    .bankCorr(bankCorr), .bankUncorr(bankUncorr), .busy(busy), .done(done),
    .eccIrq(eccIrq)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // independent model of the codeword layout
  function automatic logic [WW-1:0] model(input logic [DW-1:0] d);
    logic [4:0] c = '0;
    for (int i = 0; i < DW; i++)
      for (int k = 0; k < 5; k++)
        if (d[i] && ((posOf[i] >> k) & 1) == 1) c[k] = ~c[k];
    return {^{c, d}, c, d};
  endfunction

  function automatic logic [DW-1:0] pl(input int seed);
    return DW'(32'h9E3779B1 * (seed + 3)) | DW'(1 << 19);
  endfunction

  task automatic cleanBanks();
    for (int b = 0; b < NB; b++) begin
      expData[b] = pl(b);
      raw[b] = model(expData[b]);
    end
  endtask

  task automatic runScan();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (NB) @(negedge clk);
  endtask

  task automatic clearIrq();
    @(negedge clk) intClr = 1'b1;
    @(negedge clk) intClr = 1'b0;
  endtask

  task automatic checkBanks(input string req, input logic [NB-1:0] eC,
                            input logic [NB-1:0] eU);
    for (int b = 0; b < NB; b++)
      check(bankData[b*DW +: DW] == expData[b], req, 64'(bankData[b*DW +: DW]),
            64'(expData[b]));
    check(bankCorr == eC, {req, " corr"}, 64'(bankCorr), 64'(eC));
    check(bankUncorr == eU, {req, " uncorr"}, 64'(bankUncorr), 64'(eU));
  endtask

  task automatic t_reset();
    check(busy == 0 && done == 0 && eccIrq == 0, "R9 ctrl", {busy, done, eccIrq}, 0);
    check(bankCorr == 0 && bankUncorr == 0, "R9 flags", {bankCorr, bankUncorr}, 0);
    check(bankData == 0, "R9 data", 64'(bankData[63:0]), 0);
  endtask

  task automatic t_encoder();
    int vals [4] = '{0, 20'hFFFFF, 20'h80001, 20'h5A3C7};
    foreach (vals[i]) begin
      @(negedge clk) encPayload = DW'(vals[i]);
      #1 check(encWord == model(DW'(vals[i])), "R1 encode", 64'(encWord),
               64'(model(DW'(vals[i]))));
    end
  endtask

  task automatic t_clean();
    cleanBanks();
    runScan();
    check(done == 1 && busy == 0, "R7 done", {done, busy}, 2'b10);
    checkBanks("R2 clean", '0, '0);
    check(eccIrq == 0, "R2 no irq", eccIrq, 0);
  endtask

  task automatic t_single();
    cleanBanks();
    raw[0][22] = ~raw[0][22];
    raw[3][7]  = ~raw[3][7];
    raw[6][18] = ~raw[6][18];
    raw[7][0]  = ~raw[7][0];
    raw[9][25] = ~raw[9][25];
    runScan();
    checkBanks("R3 single", 10'b1011001001, '0);
    check(eccIrq == 1, "R8 irq set", eccIrq, 1);
    // sticky across a clean scan
    cleanBanks();
    runScan();
    check(eccIrq == 1, "R8 sticky", eccIrq, 1);
    clearIrq();
    check(eccIrq == 0, "R8 cleared", eccIrq, 0);
  endtask

  task automatic t_double();
    cleanBanks();
    raw[5][2] = ~raw[5][2];
    raw[5][9] = ~raw[5][9];
    raw[1][0] = ~raw[1][0];
    raw[1][21] = ~raw[1][21];
    expData[5] = raw[5][DW-1:0];
    expData[1] = raw[1][DW-1:0];
    runScan();
    checkBanks("R4 double", '0, 10'b0000100010);
    check(eccIrq == 1, "R4 irq", eccIrq, 1);
    clearIrq();
  endtask

  task automatic t_bypass();
    cleanBanks();
    raw[4] = {6'b101101, 20'h3C1F5};          // bit 19 clear, bad check field
    raw[8] = model(20'h7_0F0F) ^ 26'h0000101; // bit 19 clear, two flips
    expData[4] = raw[4][DW-1:0];
    expData[8] = raw[8][DW-1:0];
    runScan();
    checkBanks("R5 bypass", '0, '0);
    check(eccIrq == 0, "R5 no irq", eccIrq, 0);
  endtask

  task automatic t_order();
    cleanBanks();
    raw[2][11] = ~raw[2][11];
    raw[3][4]  = ~raw[3][4];
    runScan();
    check(bankCorr == 10'b0000001100, "R6 prior", 64'(bankCorr), 64'(10'b0000001100));
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;              // accepted edge is behind us
    check(bankCorr == 0, "R6 flags cleared", 64'(bankCorr), 0);
    repeat (3) @(negedge clk);                // banks 0..2 handled
    check(bankCorr[2] == 1 && bankCorr[3] == 0, "R6 order", 64'(bankCorr), 64'(10'b0000000100));
    check(busy == 1 && done == 0, "R6 busy", {busy, done}, 2'b10);
    start = 1'b1;                              // ignored while busy
    @(negedge clk) start = 1'b0;
    repeat (5) @(negedge clk);                // 9 banks handled
    check(done == 0 && busy == 1, "R7 not yet", {done, busy}, 2'b01);
    @(negedge clk);
    check(done == 1 && busy == 0, "R7 done timing", {done, busy}, 2'b10);
    repeat (3) @(negedge clk);
    check(done == 1 && busy == 0, "R7 restart ignored", {done, busy}, 2'b10);
    clearIrq();
  endtask

  task automatic t_setWins();
    cleanBanks();
    raw[NB-1][5] = ~raw[NB-1][5];
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (NB - 1) @(negedge clk);
    intClr = 1'b1;                             // same edge as last-bank error
    @(negedge clk) intClr = 1'b0;
    check(eccIrq == 1, "R8 set wins", eccIrq, 1);
    clearIrq();
  endtask

  initial begin
    begin
      int di = 0;
      for (int p = 1; p <= 25; p++)
        if ((p & (p - 1)) != 0) begin
          posOf[di] = p;
          di++;
        end
    end
    cleanBanks();
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    t_encoder();
    t_clean();
    t_single();
    t_double();
    t_bypass();
    t_order();
    t_setWins();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule